// File: doc/BRIEF.md
# Host Ring Stop with Any-Bin Injection

This block is the one extra stop on a slotted message ring. The ring has one stop per processor node plus this stop, which links the ring to an external host. Every clock, one bin passes the stop. A bin is a valid flag and a 48-bit message. The stop registers the bin, so it also acts as one stage of the ring.

The host loads messages into a small write queue. An ordinary stop may only use its own slot. This stop places the oldest queued message into any bin that arrives empty. That allows up to one host message per passing bin in one revolution. A message with control bit 6 set is a privileged control message, and the stop forwards it like any other. The target node decodes bit 6 and forces acceptance and a non-maskable interrupt. Bins whose destination is the host address are copied into a host receive queue and removed from the ring. If that queue is full, they keep circulating.

Top module: `host_ring_stop`

## Requirements
- R1: While reset is active, and just after it, `bin_valid_o` is 0, `hw_ready_o` is 1 and `hr_valid_o` is 0.
- R2: An arriving valid bin whose destination field (bits 27:16) is not the host address leaves the stop one clock later with its valid flag and all 48 bits unchanged.
- R3: An empty bin that arrives while the write queue is empty leaves the stop empty, with a message value of 0.
- R4: While the write queue holds messages, each arriving empty bin leaves one clock later filled with the oldest queued message. Consecutive empty bins take consecutive messages in write order.
- R5: A queued host message is kept while occupied bins pass, and those bins are not altered.
- R6: The write queue holds 4 messages. `hw_ready_o` is 0 while it is full, and a write offered then is dropped.
- R7: An arriving valid bin whose destination equals the host address (256 by default) is copied into the receive queue when that queue has room. The bin then leaves the stop empty, and it is not refilled in that clock.
- R8: When the receive queue holds its 4 messages, a host-addressed bin passes unchanged.
- R9: A host message is placed in the bin with all fields intact, including control bit 6 (message bit 46), the source field (bits 39:28) and the data field (bits 15:0).
- R10: The receive queue presents messages on `hr_msg_o` in arrival order, with `hr_valid_o` high. One message is removed in each clock where `hr_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Ring clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bin_valid_i | input | 1 | Arriving bin holds a message |
| bin_msg_i | input | 48 | Arriving bin message |
| bin_valid_o | output | 1 | Departing bin holds a message |
| bin_msg_o | output | 48 | Departing bin message |
| hw_valid_i | input | 1 | Host offers a message to send |
| hw_msg_i | input | 48 | Host message to send |
| hw_ready_o | output | 1 | Write queue has room |
| hr_valid_o | output | 1 | Receive queue holds a message |
| hr_msg_o | output | 48 | Oldest received message |
| hr_ready_i | input | 1 | Host takes the oldest received message |

## Verification
Every bin result is registered, so the departing bin is due exactly one clock after the arrival that caused it. The bench drives each arrival on the falling edge and reads `bin_msg_o` just after the next rising edge. Queue flags change in the same edge as the write or the drain. The bench therefore reads `hw_ready_o` and `hr_valid_o` just after that edge. It compares `hr_msg_o` against the expected order before each pop edge.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  localparam int MSG_W    = 48;
  localparam int DATA_LSB = 0;
  localparam int DST_LSB  = 16;
  localparam int SRC_LSB  = 28;
  localparam int CTL_LSB  = 40;
  localparam int PRIV_BIT = CTL_LSB + 6;
endpackage

// File: rtl/hrs_fifo.sv
module hrs_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  // R6: a full queue stays full until something is taken out
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
  // R10: an empty queue only becomes non-empty through a push
  a_r10_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !push_i) |=> !valid_o);
endmodule

// File: rtl/hrs_slot_ctl.sv
module hrs_slot_ctl
  import hrs_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int HOST_ADDR = 256
) (
  input  logic             bin_valid_i,
  input  logic [MSG_W-1:0] bin_msg_i,
  input  logic             tx_valid_i,
  input  logic [MSG_W-1:0] tx_msg_i,
  input  logic             rx_full_i,
  output logic             nxt_valid_o,
  output logic [MSG_W-1:0] nxt_msg_o,
  output logic             tx_pop_o,
  output logic             rx_push_o
);
  localparam logic [ADDR_W-1:0] HOST_A = ADDR_W'(HOST_ADDR);

  logic host_hit;

  assign host_hit  = bin_valid_i && (bin_msg_i[DST_LSB +: ADDR_W] == HOST_A);
  assign rx_push_o = host_hit && !rx_full_i;
  // fill only bins that arrive empty
  assign tx_pop_o  = !bin_valid_i && tx_valid_i;

  always_comb begin
    if (rx_push_o) begin
      nxt_valid_o = 1'b0;
      nxt_msg_o   = '0;
    end else if (tx_pop_o) begin
      nxt_valid_o = 1'b1;
      nxt_msg_o   = tx_msg_i;
    end else begin
      nxt_valid_o = bin_valid_i;
      nxt_msg_o   = bin_msg_i;
    end
  end
endmodule

// File: rtl/host_ring_stop.sv
module host_ring_stop
  import hrs_pkg::*;
#(
  parameter int NODES    = 256,
  parameter int ADDR_W   = 12,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bin_valid_i,
  input  logic [MSG_W-1:0] bin_msg_i,
  output logic             bin_valid_o,
  output logic [MSG_W-1:0] bin_msg_o,
  input  logic             hw_valid_i,
  input  logic [MSG_W-1:0] hw_msg_i,
  output logic             hw_ready_o,
  output logic             hr_valid_o,
  output logic [MSG_W-1:0] hr_msg_o,
  input  logic             hr_ready_i
);
  // the stop after the last node is the host
  localparam int HOST_ADDR = NODES;

  logic             tx_full, tx_valid, tx_pop;
  logic [MSG_W-1:0] tx_msg;
  logic             rx_full, rx_push;
  logic             nxt_valid;
  logic [MSG_W-1:0] nxt_msg;

  assign hw_ready_o = !tx_full;

  hrs_fifo #(.W(MSG_W), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk_i, .rst_ni,
    .push_i(hw_valid_i), .data_i(hw_msg_i), .full_o(tx_full),
    .pop_i(tx_pop), .valid_o(tx_valid), .data_o(tx_msg)
  );

  hrs_fifo #(.W(MSG_W), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk_i, .rst_ni,
    .push_i(rx_push), .data_i(bin_msg_i), .full_o(rx_full),
    .pop_i(hr_ready_i), .valid_o(hr_valid_o), .data_o(hr_msg_o)
  );

  hrs_slot_ctl #(.ADDR_W(ADDR_W), .HOST_ADDR(HOST_ADDR)) u_ctl (
    .bin_valid_i, .bin_msg_i,
    .tx_valid_i(tx_valid), .tx_msg_i(tx_msg), .rx_full_i(rx_full),
    .nxt_valid_o(nxt_valid), .nxt_msg_o(nxt_msg),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_valid_o <= 1'b0;
      bin_msg_o   <= '0;
    end else begin
      bin_valid_o <= nxt_valid;
      bin_msg_o   <= nxt_msg;
    end
  end

  // R2, R8: occupied bins not drained pass unchanged
  a_r2_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_valid_i && !rx_push) |=> (bin_valid_o && bin_msg_o == $past(bin_msg_i)));
  // R3: nothing is invented when no host message waits
  a_r3_empty_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bin_valid_i && !tx_valid) |=> !bin_valid_o);
  // R4: a filled bin carries the queue head
  a_r4_fill_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop |=> (bin_valid_o && bin_msg_o == $past(tx_msg)));
  // R7: drained bins leave empty
  a_r7_drain_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |=> !bin_valid_o);
  // R5: a waiting message is never lost while bins are occupied
  a_r5_hold_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid && bin_valid_i) |=> tx_valid);
endmodule

// File: tb/host_ring_stop_test.sv
`timescale 1ns/100ps
module host_ring_stop_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bin_valid_i = 1'b0;
  logic [47:0] bin_msg_i = '0;
  logic        bin_valid_o;
  logic [47:0] bin_msg_o;
  logic        hw_valid_i = 1'b0;
  logic [47:0] hw_msg_i = '0;
  logic        hw_ready_o;
  logic        hr_valid_o;
  logic [47:0] hr_msg_o;
  logic        hr_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  host_ring_stop uut (
    .clk_i(clk), .rst_ni, .bin_valid_i, .bin_msg_i, .bin_valid_o, .bin_msg_o,
    .hw_valid_i, .hw_msg_i, .hw_ready_o, .hr_valid_o, .hr_msg_o, .hr_ready_i
  );

  // {in_valid, in_msg, exp_valid, exp_msg}; host address 0x100 in bits 27:16
  localparam logic [97:0] VEC [6] = '{
    {1'b1, 48'h01_005_007_1234, 1'b1, 48'h01_005_007_1234},  // R2
    {1'b0, 48'h0,               1'b0, 48'h0},                // R3
    {1'b1, 48'h02_003_100_beef, 1'b0, 48'h0},                // R7
    {1'b1, 48'h40_009_00a_0001, 1'b1, 48'h40_009_00a_0001},  // R2
    {1'b0, 48'h0,               1'b0, 48'h0},                // R3
    {1'b1, 48'h00_0ff_100_0002, 1'b0, 48'h0}                 // R7
  };

  localparam logic [47:0] PASS = 48'h03_011_022_5555;

  task automatic chk(input string tag, input logic [48:0] act, input logic [48:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [47:0] m, input logic hv,
                     input logic [47:0] hm, input logic rr);
    @(negedge clk);
    bin_valid_i = v;  bin_msg_i = m;
    hw_valid_i  = hv; hw_msg_i  = hm;
    hr_ready_i  = rr;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [47:0] hmsg(input int i);
    return {8'h40, 12'h100, 12'(i + 5), 16'(16'hab00 + i)};
  endfunction

  function automatic logic [47:0] rmsg(input int i);
    return {8'h00, 12'(i + 1), 12'h100, 16'(16'h7700 + i)};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 bin_valid_o", {48'h0, bin_valid_o}, 49'h0);
    chk("R1 hw_ready_o",  {48'h0, hw_ready_o},  49'h1);
    chk("R1 hr_valid_o",  {48'h0, hr_valid_o},  49'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 after release", {48'h0, bin_valid_o}, 49'h0);

    // table walk: empty write queue, receive queue with room
    for (int i = 0; i < 6; i++) begin
      cyc(VEC[i][97], VEC[i][96:49], 1'b0, '0, 1'b0);
      chk($sformatf("R2/R3/R7 vec %0d", i), {bin_valid_o, bin_msg_o}, VEC[i][48:0]);
    end
    chk("R7 hr_valid_o", {48'h0, hr_valid_o}, 49'h1);
    chk("R10 first rx", {1'b0, hr_msg_o}, {1'b0, 48'h02_003_100_beef});
    cyc(1'b0, '0, 1'b0, '0, 1'b1);
    chk("R10 second rx", {1'b0, hr_msg_o}, {1'b0, 48'h00_0ff_100_0002});
    cyc(1'b0, '0, 1'b0, '0, 1'b1);
    chk("R10 rx empty", {48'h0, hr_valid_o}, 49'h0);

    // fill write queue while bins are occupied
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, PASS, 1'b1, hmsg(i), 1'b0);
      chk("R5 occupied bin passes", {bin_valid_o, bin_msg_o}, {1'b1, PASS});
    end
    chk("R6 ready low when full", {48'h0, hw_ready_o}, 49'h0);
    cyc(1'b1, PASS, 1'b1, 48'hff_fff_fff_ffff, 1'b0);
    chk("R5 still held", {bin_valid_o, bin_msg_o}, {1'b1, PASS});
    chk("R6 still full", {48'h0, hw_ready_o}, 49'h0);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, '0, 1'b0, '0, 1'b0);
      chk($sformatf("R4 R9 fill %0d", i), {bin_valid_o, bin_msg_o}, {1'b1, hmsg(i)});
      chk("R9 control bit 6", {48'h0, bin_msg_o[46]}, 49'h1);
      chk("R6 ready after drain", {48'h0, hw_ready_o}, 49'h1);
    end
    cyc(1'b0, '0, 1'b0, '0, 1'b0);
    chk("R6 dropped write absent", {bin_valid_o, bin_msg_o}, 49'h0);

    // pending write while a host-bound bin arrives: drained, not refilled
    cyc(1'b1, PASS, 1'b1, hmsg(9), 1'b0);
    cyc(1'b1, rmsg(0), 1'b0, '0, 1'b0);
    chk("R7 drained not refilled", {bin_valid_o, bin_msg_o}, 49'h0);
    cyc(1'b0, '0, 1'b0, '0, 1'b0);
    chk("R4 fill after drain", {bin_valid_o, bin_msg_o}, {1'b1, hmsg(9)});

    // receive queue to full, then overflow bin circulates
    for (int i = 1; i < 4; i++) begin
      cyc(1'b1, rmsg(i), 1'b0, '0, 1'b0);
      chk("R7 drain", {bin_valid_o, bin_msg_o}, 49'h0);
    end
    cyc(1'b1, rmsg(4), 1'b0, '0, 1'b0);
    chk("R8 full rx passes", {bin_valid_o, bin_msg_o}, {1'b1, rmsg(4)});
    for (int i = 0; i < 4; i++) begin
      chk($sformatf("R10 order %0d", i), {hr_valid_o, hr_msg_o}, {1'b1, rmsg(i)});
      cyc(1'b0, '0, 1'b0, '0, 1'b1);
    end
    chk("R10 drained", {48'h0, hr_valid_o}, 49'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule